// File: doc/BRIEF.md
# Boot Strap Capture and Host-Wait Handshake

This block reads a three-bit boot-mode strap and holds it for the rest of the session. It samples the strap in every clock cycle in which a power-on reset or a software reset is asserted, so a software reset can pick up a new strap setting. The held code is decoded into a one-hot select vector for the boot loaders, an idle indication and a reserved-code error flag.

The block also drives a host-wait handshake pad. It learns the pad's active polarity from the pad's external pull. It samples the pull in the same reset cycle as the strap, while its own output driver is switched off. During loading it drives the pad to its pulled level until the loader reports it is ready for data. It then drives the opposite level. When the loader reports that boot is complete, the driver is released so the pad can be used for other purposes.

Top module: `boot_strap_ctrl`

## Requirements
- R1: At every rising clock edge where `rst` or `sw_rst` is high, `mode_o` takes the value of `strap_i`, visible from the next cycle.
- R2: At rising edges where both `rst` and `sw_rst` are low, `mode_o` keeps its value whatever `strap_i` does.
- R3: `sel_o` has exactly one bit set, at index `mode_o`. Bit 0 is no boot (idle), bit 1 asynchronous parallel flash, bit 2 synchronous burst parallel flash, bit 3 SPI master, bit 4 SPI slave from host, bit 5 parallel port from host, bit 6 reserved, bit 7 UART slave from host.
- R4: `idle_o` is high for mode codes 000 and 110 and low otherwise. `rsvd_err_o` is high only for code 110.
- R5: `wait_oe_o` is low in any cycle where `rst` or `sw_rst` is high.
- R6: The level on `wait_pin_i` at the reset edge is kept as the pull level. While the pad is driven, `wait_do_o` equals the pull level when `rdy_req` is low and its inverse when `rdy_req` is high, in the same cycle.
- R7: After a reset that latched a loading mode (neither 000 nor 110), `wait_oe_o` is high from the first cycle out of reset. It falls in the cycle after an edge at which `boot_done` is high, and stays low until the next reset.
- R8: After a reset that latched code 000 or 110, `wait_oe_o` stays low until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| sw_rst | input | 1 | Software reset request, synchronous, active high |
| strap_i | input | 3 | Boot-mode strap pins |
| wait_pin_i | input | 1 | Level seen on the host-wait pad |
| rdy_req | input | 1 | Loader ready for data |
| boot_done | input | 1 | Loader finished booting |
| mode_o | output | 3 | Latched boot-mode code |
| sel_o | output | 8 | One-hot mode select |
| idle_o | output | 1 | No loading: idle or reserved mode |
| rsvd_err_o | output | 1 | Reserved code was latched |
| wait_oe_o | output | 1 | Host-wait pad output enable |
| wait_do_o | output | 1 | Host-wait pad output value |

## Verification
The bench walks all eight codes through software resets and changes the strap outside reset. A design that samples only at power-on, or that follows the strap continuously, would show the wrong held code. It tries both pull levels and toggles the ready request. An inverted or unlearned polarity would show as the wrong driven level. It also drives the pad from the bench while it is enabled, so a design that samples the pull when it should not would latch its own output. It asserts a software reset in the middle of loading, and it sends a completion pulse with idle and reserved codes latched. A design that leaves the driver on during reset, drives for idle modes, or fails to release after completion would show up on the enable.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;

    localparam int MODE_W = 3;
    localparam int NSEL   = 1 << MODE_W;

    typedef enum logic [MODE_W-1:0] {
        BM_IDLE      = 3'd0,
        BM_PF_ASYNC  = 3'd1,
        BM_PF_SYNC   = 3'd2,
        BM_SPI_MSTR  = 3'd3,
        BM_SPI_SLV   = 3'd4,
        BM_PAR_HOST  = 3'd5,
        BM_RESERVED  = 3'd6,
        BM_UART_SLV  = 3'd7
    } boot_mode_e;

    typedef enum logic [1:0] {
        PH_BOOT     = 2'd1,
        PH_RELEASED = 2'd2
    } wait_phase_e;

    typedef struct packed {
        boot_mode_e mode;
        logic       pull_hi;
    } strap_cap_t;

    function automatic logic mode_is_idle(input boot_mode_e m);
        return (m == BM_IDLE) || (m == BM_RESERVED);
    endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
    import boot_strap_pkg::*;
(
    input  logic              clk,
    input  logic              sample,
    input  logic [MODE_W-1:0] strap_i,
    input  logic              pad_i,
    output strap_cap_t        cap_o
);
    strap_cap_t cap_q;

    always_ff @(posedge clk) begin
        if (sample) begin
            cap_q.mode    <= boot_mode_e'(strap_i);
            cap_q.pull_hi <= pad_i;
        end
    end

    assign cap_o = cap_q;
endmodule

// File: rtl/boot_mode_decoder.sv
module boot_mode_decoder
    import boot_strap_pkg::*;
(
    input  boot_mode_e       mode_i,
    output logic [NSEL-1:0]  sel_o,
    output logic             idle_o,
    output logic             rsvd_o
);
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign sel_o[g] = (mode_i == boot_mode_e'(g));
    end

    assign idle_o = mode_is_idle(mode_i);
    assign rsvd_o = (mode_i == BM_RESERVED);
endmodule

// File: rtl/boot_wait_ctrl.sv
module boot_wait_ctrl
    import boot_strap_pkg::*;
(
    input  logic clk,
    input  logic in_reset,
    input  logic idle_i,
    input  logic pull_hi,
    input  logic rdy_req,
    input  logic boot_done,
    output logic oe_o,
    output logic do_o
);
    wait_phase_e phase_q;

    always_ff @(posedge clk) begin
        if (in_reset) begin
            phase_q <= PH_BOOT;
        end else if (phase_q == PH_BOOT && (idle_i || boot_done)) begin
            phase_q <= PH_RELEASED;
        end
    end

    assign oe_o = (phase_q == PH_BOOT) && !idle_i && !in_reset;
    assign do_o = pull_hi ^ rdy_req;
endmodule

// File: rtl/boot_strap_ctrl.sv
module boot_strap_ctrl
    import boot_strap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_rst,
    input  logic [2:0]  strap_i,
    input  logic        wait_pin_i,
    input  logic        rdy_req,
    input  logic        boot_done,
    output logic [2:0]  mode_o,
    output logic [7:0]  sel_o,
    output logic        idle_o,
    output logic        rsvd_err_o,
    output logic        wait_oe_o,
    output logic        wait_do_o
);
    logic       in_reset;
    strap_cap_t cap;

    assign in_reset = rst | sw_rst;

    boot_strap_latch u_latch (
        .clk     (clk),
        .sample  (in_reset),
        .strap_i (strap_i),
        .pad_i   (wait_pin_i),
        .cap_o   (cap)
    );

    boot_mode_decoder u_dec (
        .mode_i (cap.mode),
        .sel_o  (sel_o),
        .idle_o (idle_o),
        .rsvd_o (rsvd_err_o)
    );

    boot_wait_ctrl u_wait (
        .clk       (clk),
        .in_reset  (in_reset),
        .idle_i    (idle_o),
        .pull_hi   (cap.pull_hi),
        .rdy_req   (rdy_req),
        .boot_done (boot_done),
        .oe_o      (wait_oe_o),
        .do_o      (wait_do_o)
    );

    assign mode_o = cap.mode;
endmodule

// File: rtl/boot_strap_ctrl_chk.sv
module boot_strap_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sw_rst,
    input logic [2:0] strap_i,
    input logic       rdy_req,
    input logic       boot_done,
    input logic [2:0] mode_o,
    input logic [7:0] sel_o,
    input logic       idle_o,
    input logic       rsvd_err_o,
    input logic       wait_oe_o,
    input logic       wait_do_o
);
    AST_SWRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (mode_o == $past(strap_i))); // R1

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sw_rst |=> $stable(mode_o)); // R2

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        ($countones(sel_o) == 1) && sel_o[mode_o]); // R3

    AST_RSVD_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
        rsvd_err_o |-> idle_o); // R4

    AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        sw_rst |-> !wait_oe_o); // R5

    AST_RDY_FLIPS_PAD: assert property (@(posedge clk) disable iff (rst)
        (wait_oe_o && $past(wait_oe_o) && (rdy_req != $past(rdy_req)))
            |-> (wait_do_o != $past(wait_do_o))); // R6

    AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (wait_oe_o && boot_done && !sw_rst) |=> !wait_oe_o); // R7

    AST_STAY_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!wait_oe_o && !sw_rst) |=> !wait_oe_o); // R7

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> !wait_oe_o); // R8
endmodule

bind boot_strap_ctrl boot_strap_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_rst     (sw_rst),
    .strap_i    (strap_i),
    .rdy_req    (rdy_req),
    .boot_done  (boot_done),
    .mode_o     (mode_o),
    .sel_o      (sel_o),
    .idle_o     (idle_o),
    .rsvd_err_o (rsvd_err_o),
    .wait_oe_o  (wait_oe_o),
    .wait_do_o  (wait_do_o)
);

// File: tb/test_boot_strap_ctrl.sv
`timescale 1ns/1ps
module test_boot_strap_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_rst = 1'b0;
    logic [2:0] strap_i = 3'd3;
    logic       rdy_req = 1'b0;
    logic       boot_done = 1'b0;
    logic       pull_tb = 1'b1;
    logic       wait_pin_i;
    logic [2:0] mode_o;
    logic [7:0] sel_o;
    logic       idle_o, rsvd_err_o, wait_oe_o, wait_do_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // reference model state
    int  m_mode = 0;
    int  m_pull = 0;
    int  m_phase = 0;   // 0 none, 1 loading, 2 released
    bit  m_valid = 0;

    always #4 clk = ~clk;

    assign wait_pin_i = wait_oe_o ? wait_do_o : pull_tb;

    boot_strap_ctrl i_boot_strap_ctrl (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .strap_i(strap_i),
        .wait_pin_i(wait_pin_i), .rdy_req(rdy_req), .boot_done(boot_done),
        .mode_o(mode_o), .sel_o(sel_o), .idle_o(idle_o),
        .rsvd_err_o(rsvd_err_o), .wait_oe_o(wait_oe_o), .wait_do_o(wait_do_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst || sw_rst) begin
            m_mode  = int'(strap_i);
            m_pull  = int'(pull_tb);
            m_phase = 1;
            m_valid = 1;
        end else if (m_phase == 1) begin
            if (m_mode == 0 || m_mode == 6 || boot_done) m_phase = 2;
        end
    end

    always @(negedge clk) begin
        if (m_valid) begin
            int exp_oe;
            exp_oe = (m_phase == 1 && m_mode != 0 && m_mode != 6 && !rst && !sw_rst) ? 1 : 0;
            check("R1/R2 mode", int'(mode_o), m_mode);
            check("R3 sel", int'(sel_o), 1 << m_mode);
            check("R4 idle", int'(idle_o), (m_mode == 0 || m_mode == 6) ? 1 : 0);
            check("R4 rsvd", int'(rsvd_err_o), (m_mode == 6) ? 1 : 0);
            if (rst || sw_rst) check("R5 oe in reset", int'(wait_oe_o), 0);
            else if (m_mode == 0 || m_mode == 6) check("R8 oe idle", int'(wait_oe_o), 0);
            else check("R7 oe", int'(wait_oe_o), exp_oe);
            if (wait_oe_o) check("R6 pad level", int'(wait_do_o), m_pull ^ int'(rdy_req));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic soft_reset(input logic [2:0] code, input logic pull);
        strap_i = code;
        pull_tb = pull;
        sw_rst  = 1'b1;
        step(1);
        sw_rst  = 1'b0;
    endtask

    task automatic load_session();
        step(2);
        rdy_req = 1'b1; step(2);
        rdy_req = 1'b0; step(1);
        strap_i = ~strap_i; step(2);          // R2 strap change outside reset
        boot_done = 1'b1; step(1);
        boot_done = 1'b0; step(3);           // R7 released
        rdy_req = 1'b1; step(2);
        rdy_req = 1'b0;
    endtask

    initial begin
        #1;
        step(3);
        rst = 1'b0;                           // R1 power-on capture of 011, pull high
        load_session();
        for (int c = 0; c < 8; c++) begin
            soft_reset(3'(c), 1'(c & 1));     // R1 software reset re-sample
            load_session();
        end
        soft_reset(3'd5, 1'b0);
        step(2);
        rdy_req = 1'b1;
        sw_rst = 1'b1; step(1);               // R5 software reset mid-load
        sw_rst = 1'b0; step(3);
        rdy_req = 1'b0;
        soft_reset(3'd6, 1'b1);               // R8 reserved code
        boot_done = 1'b1; step(1); boot_done = 1'b0; step(2);
        rst = 1'b1; strap_i = 3'd7; pull_tb = 1'b0; step(2);
        rst = 1'b0;
        load_session();
        step(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule